// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of one SDRAM read or write burst. A controller pulses `start_i` with the first column, a burst-length code and an ordering bit. Starting the next cycle, the block puts one column on `col_o` per clock, with `valid_o` high. On the final beat it raises `last_o`. The controller forwards each column to the column-command path. Row and bank handling, command encoding, data movement and read latency stay in the controller.

Fixed bursts of four or eight beats can use either ordering:
- Ascending order wraps inside the naturally aligned block.
- Interleaved order flips the low column bits with the beat index.

A page burst steps through every column of the page, wrapping as it goes, until the controller asks it to stop. A write can be forced down to a single beat. An ordering request that makes no sense for a page burst is reported on `illegal_o` and the burst runs in ascending order.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `illegal_o` are low and `col_o` is zero until a start is accepted.
- R2: A start sampled at a clock edge makes the first beat appear in the next cycle, with `col_o` equal to the start column. Beats then follow one per cycle with `valid_o` high.
- R3: The length code selects the burst length: 2'b00 gives 4 beats, 2'b01 gives 8 beats, and 2'b10 or 2'b11 gives a page burst. `last_o` is high on the final beat of a fixed burst, and `valid_o` is low in the following cycle unless a new start was given.
- R4: With `interleave_i` low and a fixed length of L beats, beat k carries the start column plus k on its low log2(L) bits, modulo L. The upper bits stay equal to those of the start column.
- R5: With `interleave_i` high and a fixed length of L beats, beat k carries the low log2(L) bits of the start column XOR k. The upper bits stay equal to those of the start column.
- R6: A page burst puts the start column plus k, modulo 256, on beat k. It wraps from 255 to 0, returns to the start column on beat 256, and runs until stopped.
- R7: `stop_i` high during a beat makes that beat the last one: `last_o` is high in that same cycle, and the burst ends. `stop_i` while idle has no effect.
- R8: A start with both `wr_i` and `single_wr_i` high gives a one-beat burst with `last_o` high, whatever the length code. A start with only one of them high follows the length code.
- R9: A start with `interleave_i` high and a page length code raises `illegal_o` on every beat of that burst, and the columns follow the ascending order of R6. For every other combination `illegal_o` is low.
- R10: A start accepted while a burst is running abandons that burst. The new first beat appears in the next cycle. The current beat shows `last_o` only when it is the final beat or a stop is applied with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a burst with the inputs below |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 2 | Burst length: 00 = 4, 01 = 8, 1x = page |
| interleave_i | input | 1 | 1 = interleaved ordering, 0 = ascending |
| wr_i | input | 1 | The burst is a write |
| single_wr_i | input | 1 | Writes transfer one beat only |
| stop_i | input | 1 | Terminate the running burst on the current beat |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is present this cycle |
| last_o | output | 1 | Current beat is the final one |
| illegal_o | output | 1 | Current burst was requested with an unsupported ordering |

## Verification
Two events can land in one cycle, and both are provoked on purpose.

- **Burst end and new start.** A burst can end, through its final fixed beat or through a stop request, in the same cycle a new start is accepted. The bench applies `start_i` together with `stop_i` in the middle of an 8-beat burst. It also applies `start_i` on the fourth beat of a 4-beat burst, and on a running page burst without any stop.
- **How these are judged.** The scoreboard expects the old burst's beats up to that cycle, with `last_o` set only where R7 or R3 call for it. The new burst's first beat must follow in the very next cycle, with no idle gap and no extra beat.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [1:0] {
    LEN_FOUR  = 2'b00,
    LEN_EIGHT = 2'b01,
    LEN_PAGE  = 2'b10,
    LEN_PAGE2 = 2'b11
  } len_code_e;

endpackage

// File: rtl/colgen_rst_sync.sv
module colgen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];

endmodule

// File: rtl/colgen_cfg_dec.sv
module colgen_cfg_dec
  import colgen_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int SHORT_LOG = 2,
  parameter int LONG_LOG  = 3
) (
  input  logic [1:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] lim_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic             illegal_o
);

  localparam logic [COL_W-1:0] MASK_SHORT = {{(COL_W-SHORT_LOG){1'b0}}, {SHORT_LOG{1'b1}}};
  localparam logic [COL_W-1:0] MASK_LONG  = {{(COL_W-LONG_LOG){1'b0}}, {LONG_LOG{1'b1}}};
  localparam logic [COL_W-1:0] MASK_PAGE  = {COL_W{1'b1}};

  logic page_req;
  logic one_beat;

  always_comb begin
    page_req = 1'b0;
    mask_o   = MASK_SHORT;
    unique case (len_code_e'(len_code_i))
      LEN_FOUR:  mask_o = MASK_SHORT;
      LEN_EIGHT: mask_o = MASK_LONG;
      LEN_PAGE, LEN_PAGE2: begin
        mask_o   = MASK_PAGE;
        page_req = 1'b1;
      end
      default:   mask_o = MASK_SHORT;
    endcase
  end

  assign one_beat  = wr_i & single_wr_i;
  assign lim_o     = one_beat ? '0 : mask_o;
  assign full_o    = page_req & ~one_beat;
  assign illegal_o = interleave_i & page_req;
  assign ilv_o     = interleave_i & ~page_req;

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] lim_i,
  input  logic             full_i,
  output logic             active_o,
  output logic [COL_W-1:0] cnt_o,
  output logic             last_o
);

  logic             active_q, active_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign last_o = active_q & (stop_i | (~full_i & (cnt_q == lim_i)));
  assign en     = start_i | active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (start_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q) begin
      if (last_o) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d    = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;

  // R3: a final beat without a fresh start leaves the counter idle
  a_r3_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !active_o);

  // R7: stop while idle cannot wake the counter
  a_r7_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !start_i && stop_i) |=> !active_o);

endmodule

// File: rtl/colgen_col_form.sv
module colgen_col_form #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;

  assign sum = base_i + cnt_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask_i[b])  col_o[b] = base_i[b];
      else if (ilv_i)  col_o[b] = base_i[b] ^ cnt_i[b];
      else             col_o[b] = sum[b];
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W     = 8,
  parameter int SHORT_LOG = 2,
  parameter int LONG_LOG  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             wr_i,
  input  logic             single_wr_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             illegal_o
);

  logic             rst_q_n;
  logic [COL_W-1:0] dec_mask, dec_lim;
  logic             dec_full, dec_ilv, dec_illegal;

  logic [COL_W-1:0] base_q, mask_q, lim_q;
  logic             full_q, ilv_q, illegal_q;
  logic [COL_W-1:0] cnt;
  logic             active;
  logic [COL_W-1:0] col_raw;

  colgen_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  colgen_cfg_dec #(
    .COL_W     (COL_W),
    .SHORT_LOG (SHORT_LOG),
    .LONG_LOG  (LONG_LOG)
  ) u_dec (
    .len_code_i   (len_code_i),
    .interleave_i (interleave_i),
    .wr_i         (wr_i),
    .single_wr_i  (single_wr_i),
    .mask_o       (dec_mask),
    .lim_o        (dec_lim),
    .full_o       (dec_full),
    .ilv_o        (dec_ilv),
    .illegal_o    (dec_illegal)
  );

  // burst configuration, captured on start only
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      base_q    <= '0;
      mask_q    <= '0;
      lim_q     <= '0;
      full_q    <= 1'b0;
      ilv_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else if (start_i) begin
      base_q    <= start_col_i;
      mask_q    <= dec_mask;
      lim_q     <= dec_lim;
      full_q    <= dec_full;
      ilv_q     <= dec_ilv;
      illegal_q <= dec_illegal;
    end
  end

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .lim_i    (lim_q),
    .full_i   (full_q),
    .active_o (active),
    .cnt_o    (cnt),
    .last_o   (last_o)
  );

  colgen_col_form #(.COL_W(COL_W)) u_form (
    .base_i (base_q),
    .mask_i (mask_q),
    .cnt_i  (cnt),
    .ilv_i  (ilv_q),
    .col_o  (col_raw)
  );

  assign valid_o   = active;
  assign col_o     = active ? col_raw : '0;
  assign illegal_o = active & illegal_q;

  // R2 / R10: every accepted start yields its first column one cycle later
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R4 / R5: fixed bursts never touch the bits above the longest block
  a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && !last_o && !start_i && !full_q)
    |=> (col_o[COL_W-1:LONG_LOG] == $past(col_o[COL_W-1:LONG_LOG])));

  // R5: interleaved order flips bit 0 on every step
  a_r5_ilv_toggle: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && ilv_q && !last_o && !start_i) |=> (col_o[0] != $past(col_o[0])));

  // R6 / R9: page bursts step by one column, wrapping
  a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && full_q && !last_o && !start_i)
    |=> (col_o == COL_W'($past(col_o) + 1'b1)));

  // R6: a page burst keeps running without a stop
  a_r6_page_runs: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_o && full_q && !stop_i && !start_i) |=> valid_o);

  // R8: single-write bursts are one beat long
  a_r8_single_beat: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start_i && wr_i && single_wr_i) |=> last_o);

  // R1: no flag without a beat
  a_r1_flags_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_o |-> (!last_o && !illegal_o && col_o == '0));

endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [7:0] start_col_i;
  logic [1:0] len_code_i;
  logic       interleave_i;
  logic       wr_i;
  logic       single_wr_i;
  logic       stop_i;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;
  logic       illegal_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct {
    logic [7:0] col;
    logic       last;
    logic       ill;
    string      tag;
  } exp_t;

  exp_t sb[$];

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_col_i  (start_col_i),
    .len_code_i   (len_code_i),
    .interleave_i (interleave_i),
    .wr_i         (wr_i),
    .single_wr_i  (single_wr_i),
    .stop_i       (stop_i),
    .col_o        (col_o),
    .valid_o      (valid_o),
    .last_o       (last_o),
    .illegal_o    (illegal_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [1:0] code,
                                         input logic ilv, input int k);
    logic [7:0] m;
    logic [7:0] kk;
    kk = 8'(k);
    m  = (code == 2'b00) ? 8'h03 : (code == 2'b01) ? 8'h07 : 8'hFF;
    if (ilv && !code[1]) return (s & ~m) | ((s ^ kk) & m);
    return (s & ~m) | (8'(s + kk) & m);
  endfunction

  function automatic int nat_len(input logic [1:0] code, input logic wr, input logic sw);
    if (wr && sw) return 1;
    if (code[1]) return -1;
    return (code == 2'b00) ? 4 : 8;
  endfunction

  task automatic push_beats(input logic [7:0] s, input logic [1:0] code, input logic ilv,
                            input int n, input int last_at, input string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.col  = exp_col(s, code, ilv, k);
      e.last = (k == last_at);
      e.ill  = ilv & code[1];
      e.tag  = tag;
      sb.push_back(e);
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compare every produced beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL unexpected beat (R3/R7) actual col=%h expected no beat", col_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (col_o !== e.col || last_o !== e.last || illegal_o !== e.ill) begin
          failures++;
          $display("FAIL %s actual col=%h last=%b ill=%b expected col=%h last=%b ill=%b",
                   e.tag, col_o, last_o, illegal_o, e.col, e.last, e.ill);
        end
      end
    end
  end

  task automatic set_cfg(input logic [7:0] s, input logic [1:0] code, input logic ilv,
                         input logic wr, input logic sw);
    start_col_i  = s;
    len_code_i   = code;
    interleave_i = ilv;
    wr_i         = wr;
    single_wr_i  = sw;
  endtask

  task automatic burst(input logic [7:0] s, input logic [1:0] code, input logic ilv,
                       input logic wr, input logic sw, input int stop_at, input string tag);
    int n;
    int nat;
    nat = nat_len(code, wr, sw);
    n   = nat;
    if (stop_at >= 0 && (nat < 0 || stop_at < nat)) n = stop_at + 1;
    push_beats(s, code, ilv, n, n - 1, tag);
    @(posedge clk); #1;
    set_cfg(s, code, ilv, wr, sw);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k == stop_at) stop_i = 1'b1;
      @(posedge clk); #1;
      stop_i = 1'b0;
    end
    @(negedge clk);
    check(valid_o === 1'b0, {tag, " burst ended (R3)"}, valid_o, 0);
    check(sb.size() == 0, {tag, " all beats seen"}, sb.size(), 0);
  endtask

  // start B on beat k of burst A, optionally with a stop in the same cycle (R10)
  task automatic overlap(input logic [7:0] sa, input logic [1:0] ca, input int k,
                         input bit with_stop, input logic [7:0] sbc, input logic [1:0] cb,
                         input logic ib, input string tag);
    int na;
    int nb;
    bit a_last;
    na     = nat_len(ca, 1'b0, 1'b0);
    nb     = nat_len(cb, 1'b0, 1'b0);
    a_last = with_stop || (na > 0 && k == na - 1);
    push_beats(sa, ca, 1'b0, k + 1, a_last ? k : -1, tag);
    push_beats(sbc, cb, ib, nb, nb - 1, tag);
    @(posedge clk); #1;
    set_cfg(sa, ca, 1'b0, 1'b0, 1'b0);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    repeat (k) begin
      @(posedge clk); #1;
    end
    set_cfg(sbc, cb, ib, 1'b0, 1'b0);
    start_i = 1'b1;
    stop_i  = with_stop;
    @(posedge clk); #1;
    start_i = 1'b0;
    stop_i  = 1'b0;
    repeat (nb) begin
      @(posedge clk); #1;
    end
    @(negedge clk);
    check(valid_o === 1'b0, {tag, " idle after B"}, valid_o, 0);
    check(sb.size() == 0, {tag, " all beats seen"}, sb.size(), 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    stop_i  = 1'b0;
    set_cfg(8'h00, 2'b00, 1'b0, 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(valid_o === 1'b0, "R1 valid after reset", valid_o, 0);
    check(last_o === 1'b0, "R1 last after reset", last_o, 0);
    check(illegal_o === 1'b0, "R1 illegal after reset", illegal_o, 0);
    check(col_o === 8'h00, "R1 col after reset", col_o, 0);

    burst(8'h13, 2'b00, 1'b0, 1'b0, 1'b0, -1, "R2 R3 R4 seq4");
    burst(8'h2D, 2'b01, 1'b0, 1'b0, 1'b0, -1, "R3 R4 seq8");
    burst(8'h16, 2'b00, 1'b1, 1'b0, 1'b0, -1, "R5 ilv4");
    burst(8'h5B, 2'b01, 1'b1, 1'b0, 1'b0, -1, "R5 ilv8");
    burst(8'hF0, 2'b10, 1'b0, 1'b0, 1'b0, 299, "R6 page wrap");
    burst(8'h80, 2'b11, 1'b0, 1'b0, 1'b0, 10, "R3 R6 page code11");
    burst(8'hA7, 2'b10, 1'b1, 1'b0, 1'b0, 5, "R9 ilv page");
    burst(8'h33, 2'b01, 1'b0, 1'b1, 1'b1, -1, "R8 single write");
    burst(8'h33, 2'b10, 1'b1, 1'b1, 1'b1, -1, "R8 R9 single write page");
    burst(8'h33, 2'b01, 1'b0, 1'b1, 1'b0, -1, "R8 write full length");
    burst(8'h33, 2'b00, 1'b0, 1'b0, 1'b1, -1, "R8 read ignores single");
    burst(8'h44, 2'b01, 1'b0, 1'b0, 1'b0, 2, "R7 stop fixed");

    // R7: stop while idle does nothing
    @(posedge clk); #1;
    stop_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(valid_o === 1'b0 && last_o === 1'b0, "R7 idle stop", valid_o, 0);
    end
    @(posedge clk); #1;
    stop_i = 1'b0;

    overlap(8'h40, 2'b01, 2, 1'b1, 8'h25, 2'b00, 1'b1, "R10 stop+start");
    overlap(8'h10, 2'b00, 3, 1'b0, 8'h6E, 2'b00, 1'b0, "R10 final+start");
    overlap(8'hFC, 2'b10, 5, 1'b0, 8'h09, 2'b01, 1'b1, "R10 page restart");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule